// File: doc/BRIEF.md
# Super I/O Index/Data Configuration Port

This block is a byte-wide configuration register file for a legacy peripheral group. It is reached through a pair of adjacent I/O ports. A write to the lower port, the index port, picks a register. The upper port, the data port, then reads or writes the register that the index picks. The index is kept in register 0 of the file. For that reason a data-port read at index 0 returns zero, and a data-port write at index 0 replaces the index.

The block drives decoded outputs for the rest of the chip:
- the floppy controller I/O base,
- the parallel port I/O base,
- two serial port I/O bases,
- the function-select byte.

Each base register holds an address divided by four. The output is that value shifted left by two bits, which gives a 10-bit I/O address. An external enable, taken from a bridge configuration bit, gates both ports. While the enable is low the ports do not respond.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset every register reads 0x00, with these exceptions: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. The index is 0 after reset.
- R2: A write to address 0x3F0 (the index port) stores the byte as the index. A read of 0x3F0 returns the current index in the same cycle.
- R3: A write to address 0x3F1 (the data port) stores the byte into the register that the index selects. A data-port read from the next cycle onward returns that byte.
- R4: Register 0xE0 is read-only. It always reads 0x3C, and writes to it have no effect.
- R5: A data-port read while the index is 0 returns 0x00. A data-port write while the index is 0 replaces the index.
- R6: The four base outputs each equal a register shifted left by two bits: `fdc_base` from 0xE3, `lpt_base` from 0xE6, `com1_base` from 0xE7 and `com2_base` from 0xE8. After reset they are 0x3F0, 0x378, 0x3F8 and 0x2F8.
- R7: `func_sel` equals register 0xE2. Its reset value is 0x03, which has all functions disabled.
- R8: While `port_en` is low, reads of either port return 0xFF, and writes change no register and no output.
- R9: Accesses to any address other than 0x3F0 and 0x3F1 return 0xFF and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port decode enable from the bridge configuration bit |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Single-byte write strobe |
| io_rd | input | 1 | Single-byte read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| fdc_base | output | 10 | Floppy controller I/O base |
| lpt_base | output | 10 | Parallel port I/O base |
| com1_base | output | 10 | First serial port I/O base |
| com2_base | output | 10 | Second serial port I/O base |
| func_sel | output | 8 | Function-select register |

## Verification
Reads are combinational, so the bench drives a read strobe on the falling edge and samples `io_rdata` before the next rising edge. Writes take effect at the rising edge that follows the strobe. Stored values and the decoded base outputs are due one cycle after a write, and the bench compares them only after that edge. The sweep writes and reads back every index. The bench then checks the base outputs arithmetically against its own copy of the register contents.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   localparam int unsigned IDX_W = 8;
   localparam int unsigned DAT_W = 8;

   localparam logic [7:0] IDX_ID   = 8'hE0;
   localparam logic [7:0] IDX_FSEL = 8'hE2;
   localparam logic [7:0] IDX_FDC  = 8'hE3;
   localparam logic [7:0] IDX_LPT  = 8'hE6;
   localparam logic [7:0] IDX_COM1 = 8'hE7;
   localparam logic [7:0] IDX_COM2 = 8'hE8;

   localparam logic [7:0] ID_VALUE = 8'h3C;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_IDX  = 2'd1,
      HIT_DAT  = 2'd2
   } port_hit_e;

   function automatic logic [7:0] reset_value(input logic [7:0] idx);
      case (idx)
         IDX_ID:   return ID_VALUE;
         IDX_FSEL: return 8'h03;
         IDX_FDC:  return 8'hFC;
         IDX_LPT:  return 8'hDE;
         IDX_COM1: return 8'hFE;
         IDX_COM2: return 8'hBE;
         default:  return 8'h00;
      endcase
   endfunction

   function automatic logic is_readonly(input logic [7:0] idx);
      return idx == IDX_ID;
   endfunction
endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
   import sio_cfg_pkg::*;
#(
   parameter int unsigned          ADDR_W    = 16,
   parameter logic [ADDR_W-1:0]    PORT_BASE = 16'h03F0
) (
   input  logic              port_en,
   input  logic [ADDR_W-1:0] io_addr,
   output port_hit_e         hit
);
   localparam logic [ADDR_W-1:0] DATA_PORT = PORT_BASE + 1'b1;

   generate
      if (PORT_BASE[0] != 1'b0) begin : g_bad_base
         $error("PORT_BASE must be even");
      end
   endgenerate

   always_comb begin
      hit = HIT_NONE;
      if (port_en) begin
         if (io_addr == PORT_BASE)      hit = HIT_IDX;
         else if (io_addr == DATA_PORT) hit = HIT_DAT;
      end
   end
endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
   import sio_cfg_pkg::*;
#(
   parameter int unsigned AW = IDX_W,
   parameter int unsigned DW = DAT_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_idx,
   input  logic [DW-1:0]          wr_data,
   input  logic [AW-1:0]          rd_idx,
   output logic [DW-1:0]          rd_data,
   output logic [(2**AW)*DW-1:0]  file_q
);
   localparam int unsigned DEPTH = 2 ** AW;

   generate
      if (AW != 8 || DW != 8) begin : g_bad_geom
         $error("register file must be 256 x 8 to hold the fixed map");
      end
   endgenerate

   logic [DEPTH-1:0][DW-1:0] regs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) regs_q[i] <= reset_value(8'(i));
      end else if (wr_en && !is_readonly(8'(wr_idx))) begin
         regs_q[wr_idx] <= wr_data;
      end
   end

   assign rd_data = regs_q[rd_idx];
   assign file_q  = regs_q;

   assert_ro_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (wr_idx == AW'(IDX_ID)) |=> regs_q[IDX_ID] == $past(regs_q[IDX_ID]));

   assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (wr_idx != AW'(IDX_ID)) |=> regs_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/sio_base_decode.sv
module sio_base_decode #(
   parameter int unsigned DW    = 8,
   parameter int unsigned NCH   = 4,
   parameter int unsigned SHIFT = 2
) (
   input  logic [NCH-1:0][DW-1:0]       base_reg,
   output logic [NCH-1:0][DW+SHIFT-1:0] base_addr
);
   generate
      if (NCH == 0) begin : g_bad_nch
         $error("NCH must be nonzero");
      end
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         assign base_addr[c] = {base_reg[c], {SHIFT{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 16,
   parameter logic [15:0]       PORT_BASE = 16'h03F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic [9:0]        fdc_base,
   output logic [9:0]        lpt_base,
   output logic [9:0]        com1_base,
   output logic [9:0]        com2_base,
   output logic [7:0]        func_sel
);
   localparam int unsigned DEPTH = 2 ** IDX_W;
   localparam int unsigned NCH   = 4;
   localparam int unsigned BW    = DAT_W + 2;

   port_hit_e                    hit;
   logic                         wr_en;
   logic [IDX_W-1:0]             wr_idx;
   logic [IDX_W-1:0]             cur_idx;
   logic [DAT_W-1:0]             sel_data;
   logic [DEPTH*DAT_W-1:0]       file_q;
   logic [DEPTH-1:0][DAT_W-1:0]  file_v;
   logic [NCH-1:0][DAT_W-1:0]    base_reg;
   logic [NCH-1:0][BW-1:0]       base_addr;

   sio_addr_decode #(.ADDR_W(ADDR_W), .PORT_BASE(ADDR_W'(PORT_BASE))) u_dec (
      .port_en (port_en),
      .io_addr (io_addr),
      .hit     (hit)
   );

   assign wr_en  = io_wr && (hit != HIT_NONE);
   assign wr_idx = (hit == HIT_IDX) ? '0 : cur_idx;

   sio_reg_file #(.AW(IDX_W), .DW(DAT_W)) u_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (io_wdata),
      .rd_idx  (cur_idx),
      .rd_data (sel_data),
      .file_q  (file_q)
   );

   assign file_v  = file_q;
   assign cur_idx = file_v[0];

   assign base_reg[0] = file_v[IDX_FDC];
   assign base_reg[1] = file_v[IDX_LPT];
   assign base_reg[2] = file_v[IDX_COM1];
   assign base_reg[3] = file_v[IDX_COM2];

   sio_base_decode #(.DW(DAT_W), .NCH(NCH), .SHIFT(2)) u_base (
      .base_reg  (base_reg),
      .base_addr (base_addr)
   );

   assign fdc_base  = base_addr[0];
   assign lpt_base  = base_addr[1];
   assign com1_base = base_addr[2];
   assign com2_base = base_addr[3];
   assign func_sel  = file_v[IDX_FSEL];

   always_comb begin
      unique case (hit)
         HIT_IDX: io_rdata = cur_idx;
         HIT_DAT: io_rdata = (cur_idx == '0) ? 8'h00 : sel_data;
         default: io_rdata = 8'hFF;
      endcase
   end

   assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr && port_en && (io_addr == ADDR_W'(PORT_BASE)) |=> cur_idx == $past(io_wdata));

   assert_off_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> $stable(cur_idx) && $stable(fdc_base) && $stable(func_sel));

   assert_fdc_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr && (hit == HIT_DAT) && (cur_idx == IDX_FDC) |=> fdc_base == {$past(io_wdata), 2'b00});

   assert_zero_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == HIT_DAT) && (cur_idx == '0) |-> io_rdata == 8'h00);
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        port_en;
   logic [15:0] io_addr;
   logic        io_wr;
   logic        io_rd;
   logic [7:0]  io_wdata;
   logic [7:0]  io_rdata;
   logic [9:0]  fdc_base, lpt_base, com1_base, com2_base;
   logic [7:0]  func_sel;

   int total = 0;
   int bad   = 0;
   logic [7:0] model [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   sio_cfg_port u_dut (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .io_addr(io_addr),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .fdc_base(fdc_base), .lpt_base(lpt_base), .com1_base(com1_base),
      .com2_base(com2_base), .func_sel(func_sel)
   );

   function automatic logic [7:0] rst_map(input int i);
      case (i)
         8'hE0: return 8'h3C;
         8'hE2: return 8'h03;
         8'hE3: return 8'hFC;
         8'hE6: return 8'hDE;
         8'hE7: return 8'hFE;
         8'hE8: return 8'hBE;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(posedge clk);
      #1 io_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #2 d = io_rdata;
      io_rd = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < 256; i++) model[i] = rst_map(i);
   endtask

   task automatic check_outputs(input string req);
      check(req, 16'(fdc_base),  16'({model[8'hE3], 2'b00}));
      check(req, 16'(lpt_base),  16'({model[8'hE6], 2'b00}));
      check(req, 16'(com1_base), 16'({model[8'hE7], 2'b00}));
      check(req, 16'(com2_base), 16'({model[8'hE8], 2'b00}));
      check(req, 16'(func_sel),  16'(model[8'hE2]));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      rst_n = 1'b0; port_en = 1'b1; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
      do_reset();

      // R1: reset index and full register sweep; R6/R7 reset outputs
      bus_read(16'h03F0, rd); check("R1 index", 16'(rd), 16'h0000);
      for (int i = 1; i < 256; i++) begin
         bus_write(16'h03F0, 8'(i));
         bus_read(16'h03F1, rd);
         check("R1 reset map", 16'(rd), 16'(rst_map(i)));
      end
      check("R6 fdc reset",  16'(fdc_base),  16'h03F0);
      check("R6 lpt reset",  16'(lpt_base),  16'h0378);
      check("R6 com1 reset", 16'(com1_base), 16'h03F8);
      check("R6 com2 reset", 16'(com2_base), 16'h02F8);
      check("R7 fsel reset", 16'(func_sel),  16'h0003);

      // R2/R3/R4: write every nonzero index, read back index and data
      for (int i = 1; i < 256; i++) begin
         bus_write(16'h03F0, 8'(i));
         bus_read(16'h03F0, rd);
         check("R2 index readback", 16'(rd), 16'(i));
         bus_write(16'h03F1, 8'(i) ^ 8'hA5);
         if (i != 8'hE0) model[i] = 8'(i) ^ 8'hA5;
      end
      for (int i = 1; i < 256; i++) begin
         bus_write(16'h03F0, 8'(i));
         bus_read(16'h03F1, rd);
         check(i == 8'hE0 ? "R4 read-only" : "R3 stored", 16'(rd), 16'(model[i]));
      end
      check_outputs("R6 R7 after sweep");

      // R6: distinct base patterns
      for (int v = 0; v < 256; v += 37) begin
         bus_write(16'h03F0, 8'hE7);
         bus_write(16'h03F1, 8'(v));
         model[8'hE7] = 8'(v);
         check("R6 com1 pattern", 16'(com1_base), 16'({8'(v), 2'b00}));
      end

      // R5: index 0 reads 0, data write replaces index
      bus_write(16'h03F0, 8'h00);
      bus_read(16'h03F1, rd); check("R5 zero read", 16'(rd), 16'h0000);
      bus_write(16'h03F1, 8'hE3);
      bus_read(16'h03F0, rd); check("R5 index replace", 16'(rd), 16'h00E3);
      bus_read(16'h03F1, rd); check("R5 follows new index", 16'(rd), 16'(model[8'hE3]));

      // R8: disabled ports
      port_en = 1'b0;
      bus_read(16'h03F0, rd); check("R8 idx read off", 16'(rd), 16'h00FF);
      bus_read(16'h03F1, rd); check("R8 dat read off", 16'(rd), 16'h00FF);
      bus_write(16'h03F1, 8'h11);
      bus_write(16'h03F0, 8'h55);
      check_outputs("R8 outputs off");
      port_en = 1'b1;
      bus_read(16'h03F0, rd); check("R8 index kept", 16'(rd), 16'h00E3);
      bus_read(16'h03F1, rd); check("R8 data kept", 16'(rd), 16'(model[8'hE3]));

      // R9: neighbouring addresses do nothing
      bus_write(16'h03F2, 8'h77);
      bus_write(16'h02F0, 8'h66);
      bus_read(16'h03F2, rd); check("R9 read other", 16'(rd), 16'h00FF);
      bus_read(16'h03EF, rd); check("R9 read below", 16'(rd), 16'h00FF);
      bus_read(16'h03F0, rd); check("R9 index kept", 16'(rd), 16'h00E3);
      check_outputs("R9 outputs kept");

      // R1: second reset restores map
      do_reset();
      bus_read(16'h03F0, rd); check("R1 index after reset", 16'(rd), 16'h0000);
      check_outputs("R1 outputs after reset");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule